// File: doc/BRIEF.md
# Asynchronous Bus Cycle Controller

This block is the processor-side master of an asynchronous, handshake-terminated bus. The data path is 16 bits wide and the byte address is 24 bits wide. An internal requester presents one transfer at a time on a simple valid/ready port. A transfer carries an address, a direction, a size (byte or word), a three-bit address-space code and a flag that marks an interrupt-acknowledge cycle. The controller drives the address and the space code, runs one strobe sequence per bus cycle and waits for the addressed device to answer. The device answers with an active-low transfer acknowledge or an active-low bus error. The controller then hands read data or an error status back to the requester.

Two byte-lane strobes select which half of the data bus carries valid data. In the wide mode a word moves in one bus cycle. In the byte-bus mode only the lower strobe and data bits 7..0 are used, and a word is split into two bus cycles: the high-order byte at the even address first, then the low-order byte. An interrupt-acknowledge cycle is a byte read with an all-ones space code. The level being acknowledged sits on address bits 3..1, every other address bit is forced high, and the responder returns a vector on the low data byte. The data outputs are enabled only during write cycles.

Top module: `bus_cycle_ctrl`

## Requirements
- R1: After reset the address strobe and both byte strobes are high (negated), the direction line is high (read), the data output enable is low, `req_ready_o` is high and `rsp_valid_o` is low.
- R2: For each bus cycle there is one setup clock. In that clock the address, space code and direction are driven and all strobes are negated. The address strobe and the selected byte strobes then go low and stay low until a clock edge samples a low acknowledge or a low bus error. All strobes are high in the clock after that edge. After the final bus cycle of a transfer, `rsp_valid_o` is high for the one clock that follows.
- R3: The address and the space code do not change while the address strobe is low.
- R4: In the wide mode the strobes and lanes work as follows:
  - A byte at an even address asserts only the upper strobe (bits 15..8).
  - A byte at an odd address asserts only the lower strobe (bits 7..0).
  - A word asserts both strobes.
  - Byte write data `req_wdata_i[7:0]` appears on both halves of `bus_dout_o`.
  - A byte read returns the selected lane in `rsp_rdata_o[7:0]` with bits 15..8 zero.
  - A word read returns `bus_din_i` unchanged.
- R5: During a write the direction line is low and `bus_doe_o` is high, from the setup clock through the clock after termination. At all other times the direction line is high and `bus_doe_o` is low.
- R6: In the byte-bus mode (`byte_bus_i` = 1) the upper strobe is never asserted. A byte transfer is one bus cycle on the lower strobe with data on bits 7..0 and the read result in `rsp_rdata_o[7:0]`.
- R7: In the byte-bus mode a word is two bus cycles. The first is at the even address and carries `req_wdata_i[15:8]` or returns `rsp_rdata_o[15:8]`. The second is at the address plus one and carries `req_wdata_i[7:0]` or returns `rsp_rdata_o[7:0]`.
- R8: An interrupt acknowledge has the following properties:
  - The address is bits 23..4 all ones, the level on bits 3..1, and bit 0 one.
  - The space code is 3'b111.
  - The cycle is a read whatever `req_write_i` says.
  - Only the lower strobe is asserted.
  - The vector on `bus_din_i[7:0]` is returned in `rsp_rdata_o[7:0]`.
- R9: A low bus error ends the bus cycle with `rsp_err_o` = 1 in the response. In a split word no second bus cycle follows an error on the first.
- R10: A word request at an odd address (not an acknowledge) produces a response with `rsp_err_o` = 1 in the clock after acceptance, and the address strobe stays high.
- R11: If acknowledge and bus error are sampled low together, the bus error wins and the response carries `rsp_err_o` = 1.
- R12: A read that ends with an acknowledge returns `rsp_err_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| byte_bus_i | input | 1 | 1 selects the byte-bus mode; change only while idle |
| req_valid_i | input | 1 | Transfer request present |
| req_ready_o | output | 1 | Controller idle and able to accept a request |
| req_addr_i | input | 24 | Byte address |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_word_i | input | 1 | 1 = word, 0 = byte |
| req_fc_i | input | 3 | Address-space code for the cycle |
| req_iack_i | input | 1 | Request is an interrupt acknowledge |
| req_level_i | input | 3 | Level being acknowledged |
| req_wdata_i | input | 16 | Write data (a byte in bits 7..0) |
| rsp_valid_o | output | 1 | One-clock response pulse |
| rsp_err_o | output | 1 | Response is an error |
| rsp_rdata_o | output | 16 | Read data or vector |
| bus_addr_o | output | 24 | Bus address |
| bus_fc_o | output | 3 | Bus space code |
| bus_as_n_o | output | 1 | Address strobe, active low |
| bus_rw_o | output | 1 | High = read, low = write |
| bus_uds_n_o | output | 1 | Upper byte strobe (bits 15..8), active low |
| bus_lds_n_o | output | 1 | Lower byte strobe (bits 7..0), active low |
| bus_dout_o | output | 16 | Write data to the bus |
| bus_doe_o | output | 1 | Output enable for `bus_dout_o` |
| bus_din_i | input | 16 | Read data from the bus |
| bus_ack_n_i | input | 1 | Transfer acknowledge, active low |
| bus_berr_n_i | input | 1 | Bus error, active low |

## Verification
The bench builds the controller with its default widths: a 24-bit address, a 16-bit bus, a 3-bit level and a 3-bit space code. It sweeps every combination of the following, in both bus modes:
- the two low address bits;
- direction and size;
- acknowledge, bus error or both together;
- zero to two wait clocks.

It also runs an acknowledge for every level. This reaches every lane choice, both halves of a split word, the odd-word rejection and error priority. The responder returns a different data pattern for each bus cycle, so a swapped or stale byte shows up in the result.

// File: rtl/bcc_pkg.sv
package bcc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_ACTIVE = 2'd2,
        ST_TERM   = 2'd3
    } bcc_state_e;

endpackage

// File: rtl/bcc_addr_form.sv
// Forms the first bus address of a transfer: the request address, or the
// acknowledge pattern (upper bits high, level on bits above bit 0, bit 0 high).
module bcc_addr_form #(
    parameter int ADDR_W = 24,
    parameter int LVL_W  = 3
) (
    input  logic              iack_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [LVL_W-1:0]  level_i,
    output logic [ADDR_W-1:0] addr_o
);
    localparam int HI_W = ADDR_W - LVL_W - 1;

    always_comb begin
        if (iack_i) begin
            addr_o = {{HI_W{1'b1}}, level_i, 1'b1};
        end else begin
            addr_o = addr_i;
        end
    end
endmodule

// File: rtl/bcc_lane_sel.sv
// Chooses byte strobes and places write data onto the bus lanes.
module bcc_lane_sel #(
    parameter int DATA_W = 16
) (
    input  logic              narrow_i,
    input  logic              word_i,
    input  logic              a0_i,
    input  logic              seg_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              upper_en_o,
    output logic              lower_en_o,
    output logic [DATA_W-1:0] wr_bus_o
);
    localparam int HALF = DATA_W / 2;

    always_comb begin
        if (narrow_i) begin
            upper_en_o = 1'b0;
            lower_en_o = 1'b1;
            if (word_i && !seg_i) begin
                wr_bus_o = {2{wdata_i[DATA_W-1:HALF]}};
            end else begin
                wr_bus_o = {2{wdata_i[HALF-1:0]}};
            end
        end else if (word_i) begin
            upper_en_o = 1'b1;
            lower_en_o = 1'b1;
            wr_bus_o   = wdata_i;
        end else begin
            upper_en_o = !a0_i;
            lower_en_o = a0_i;
            wr_bus_o   = {2{wdata_i[HALF-1:0]}};
        end
    end
endmodule

// File: rtl/bcc_rd_merge.sv
// Folds the byte or word sampled at termination into the read result.
module bcc_rd_merge #(
    parameter int DATA_W = 16
) (
    input  logic              narrow_i,
    input  logic              word_i,
    input  logic              a0_i,
    input  logic              seg_i,
    input  logic [DATA_W-1:0] din_i,
    input  logic [DATA_W-1:0] cur_i,
    output logic [DATA_W-1:0] next_o
);
    localparam int HALF = DATA_W / 2;

    always_comb begin
        if (narrow_i) begin
            if (word_i && !seg_i) begin
                next_o = {din_i[HALF-1:0], cur_i[HALF-1:0]};
            end else if (word_i) begin
                next_o = {cur_i[DATA_W-1:HALF], din_i[HALF-1:0]};
            end else begin
                next_o = {{HALF{1'b0}}, din_i[HALF-1:0]};
            end
        end else if (word_i) begin
            next_o = din_i;
        end else if (a0_i) begin
            next_o = {{HALF{1'b0}}, din_i[HALF-1:0]};
        end else begin
            next_o = {{HALF{1'b0}}, din_i[DATA_W-1:HALF]};
        end
    end
endmodule

// File: rtl/bus_cycle_ctrl.sv
module bus_cycle_ctrl
    import bcc_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16,
    parameter int FC_W   = 3,
    parameter int LVL_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_bus_i,
    input  logic              req_valid_i,
    output logic              req_ready_o,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic              req_write_i,
    input  logic              req_word_i,
    input  logic [FC_W-1:0]   req_fc_i,
    input  logic              req_iack_i,
    input  logic [LVL_W-1:0]  req_level_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    output logic              rsp_valid_o,
    output logic              rsp_err_o,
    output logic [DATA_W-1:0] rsp_rdata_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [FC_W-1:0]   bus_fc_o,
    output logic              bus_as_n_o,
    output logic              bus_rw_o,
    output logic              bus_uds_n_o,
    output logic              bus_lds_n_o,
    output logic [DATA_W-1:0] bus_dout_o,
    output logic              bus_doe_o,
    input  logic [DATA_W-1:0] bus_din_i,
    input  logic              bus_ack_n_i,
    input  logic              bus_berr_n_i
);
    localparam logic [FC_W-1:0] FC_IACK = {FC_W{1'b1}};

    typedef struct packed {
        bcc_state_e        st;
        logic              narrow;
        logic [ADDR_W-1:0] addr;
        logic              wr;
        logic              word;
        logic [FC_W-1:0]   fc;
        logic              seg;
        logic              last;
        logic              berr_seen;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              rsp_v;
        logic              rsp_e;
    } regs_t;

    regs_t q, d;

    logic [ADDR_W-1:0] start_addr;
    logic              upper_en;
    logic              lower_en;
    logic [DATA_W-1:0] wr_bus;
    logic [DATA_W-1:0] rd_next;

    bcc_addr_form #(.ADDR_W(ADDR_W), .LVL_W(LVL_W)) addr_form_i (
        .iack_i  (req_iack_i),
        .addr_i  (req_addr_i),
        .level_i (req_level_i),
        .addr_o  (start_addr)
    );

    bcc_lane_sel #(.DATA_W(DATA_W)) lane_sel_i (
        .narrow_i   (q.narrow),
        .word_i     (q.word),
        .a0_i       (q.addr[0]),
        .seg_i      (q.seg),
        .wdata_i    (q.wdata),
        .upper_en_o (upper_en),
        .lower_en_o (lower_en),
        .wr_bus_o   (wr_bus)
    );

    bcc_rd_merge #(.DATA_W(DATA_W)) rd_merge_i (
        .narrow_i (q.narrow),
        .word_i   (q.word),
        .a0_i     (q.addr[0]),
        .seg_i    (q.seg),
        .din_i    (bus_din_i),
        .cur_i    (q.rdata),
        .next_o   (rd_next)
    );

    always_comb begin
        d       = q;
        d.rsp_v = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (req_valid_i) begin
                    if (req_word_i && req_addr_i[0] && !req_iack_i) begin
                        d.rsp_v = 1'b1;
                        d.rsp_e = 1'b1;
                        d.rdata = '0;
                    end else begin
                        d.st        = ST_SETUP;
                        d.narrow    = byte_bus_i;
                        d.addr      = start_addr;
                        d.wr        = req_write_i && !req_iack_i;
                        d.word      = req_word_i && !req_iack_i;
                        d.fc        = req_iack_i ? FC_IACK : req_fc_i;
                        d.seg       = 1'b0;
                        d.last      = 1'b0;
                        d.berr_seen = 1'b0;
                        d.wdata     = req_wdata_i;
                        d.rdata     = '0;
                    end
                end
            end
            ST_SETUP: begin
                d.st = ST_ACTIVE;
            end
            ST_ACTIVE: begin
                if (!bus_berr_n_i) begin
                    d.st        = ST_TERM;
                    d.berr_seen = 1'b1;
                    d.last      = 1'b1;
                end else if (!bus_ack_n_i) begin
                    d.st   = ST_TERM;
                    d.last = !(q.narrow && q.word && !q.seg);
                    if (!q.wr) begin
                        d.rdata = rd_next;
                    end
                end
            end
            ST_TERM: begin
                if (q.last) begin
                    d.st    = ST_IDLE;
                    d.rsp_v = 1'b1;
                    d.rsp_e = q.berr_seen;
                end else begin
                    d.st      = ST_SETUP;
                    d.seg     = 1'b1;
                    d.addr[0] = 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, narrow: 1'b0, addr: '0, wr: 1'b0, word: 1'b0,
                   fc: '0, seg: 1'b0, last: 1'b0, berr_seen: 1'b0,
                   wdata: '0, rdata: '0, rsp_v: 1'b0, rsp_e: 1'b0};
        end else begin
            q <= d;
        end
    end

    logic active;
    logic in_cycle;

    assign active      = (q.st == ST_ACTIVE);
    assign in_cycle    = (q.st != ST_IDLE);
    assign req_ready_o = (q.st == ST_IDLE);
    assign rsp_valid_o = q.rsp_v;
    assign rsp_err_o   = q.rsp_e;
    assign rsp_rdata_o = q.rdata;
    assign bus_addr_o  = q.addr;
    assign bus_fc_o    = q.fc;
    assign bus_as_n_o  = !active;
    assign bus_uds_n_o = !(active && upper_en);
    assign bus_lds_n_o = !(active && lower_en);
    assign bus_rw_o    = !(in_cycle && q.wr);
    assign bus_doe_o   = in_cycle && q.wr;
    assign bus_dout_o  = wr_bus;
endmodule

// File: rtl/bcc_checker.sv
module bcc_checker #(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16,
    parameter int FC_W   = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              byte_bus_i,
    input logic [ADDR_W-1:0] bus_addr_o,
    input logic [FC_W-1:0]   bus_fc_o,
    input logic              bus_as_n_o,
    input logic              bus_rw_o,
    input logic              bus_uds_n_o,
    input logic              bus_lds_n_o,
    input logic              bus_doe_o,
    input logic              bus_ack_n_i,
    input logic              bus_berr_n_i,
    input logic [DATA_W-1:0] bus_din_i
);
    assert_strobe_under_as_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_as_n_o |-> (bus_uds_n_o && bus_lds_n_o));

    assert_release_after_term_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_as_n_o && (!bus_ack_n_i || !bus_berr_n_i)) |=> bus_as_n_o);

    assert_addr_fc_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_as_n_o && $past(!bus_as_n_o)) |-> ($stable(bus_addr_o) && $stable(bus_fc_o)));

    assert_drive_only_on_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_doe_o |-> !bus_rw_o);

    assert_no_upper_in_byte_bus_R6: assert property (@(posedge clk) disable iff (!rst_n)
        byte_bus_i |-> bus_uds_n_o);

    assert_word_even_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_as_n_o && !bus_uds_n_o && !bus_lds_n_o) |-> !bus_addr_o[0]);

    logic unused_din;
    assign unused_din = ^bus_din_i;
endmodule

bind bus_cycle_ctrl bcc_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .FC_W(FC_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .byte_bus_i   (byte_bus_i),
    .bus_addr_o   (bus_addr_o),
    .bus_fc_o     (bus_fc_o),
    .bus_as_n_o   (bus_as_n_o),
    .bus_rw_o     (bus_rw_o),
    .bus_uds_n_o  (bus_uds_n_o),
    .bus_lds_n_o  (bus_lds_n_o),
    .bus_doe_o    (bus_doe_o),
    .bus_ack_n_i  (bus_ack_n_i),
    .bus_berr_n_i (bus_berr_n_i),
    .bus_din_i    (bus_din_i)
);

// File: tb/bus_cycle_ctrl_tb_top.sv
module bus_cycle_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        byte_bus = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [23:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        req_word = 1'b0;
    logic [2:0]  req_fc = '0;
    logic        req_iack = 1'b0;
    logic [2:0]  req_level = '0;
    logic [15:0] req_wdata = '0;
    logic        rsp_valid;
    logic        rsp_err;
    logic [15:0] rsp_rdata;
    logic [23:0] bus_addr;
    logic [2:0]  bus_fc;
    logic        as_n;
    logic        rw;
    logic        uds_n;
    logic        lds_n;
    logic [15:0] dout;
    logic        doe;
    logic [15:0] bus_din = '0;
    logic        ack_n = 1'b1;
    logic        berr_n = 1'b1;

    int n_chk  = 0;
    int n_fail = 0;
    int n_txn  = 0;
    int cyc    = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_cycle_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .byte_bus_i(byte_bus),
        .req_valid_i(req_valid), .req_ready_o(req_ready), .req_addr_i(req_addr),
        .req_write_i(req_write), .req_word_i(req_word), .req_fc_i(req_fc),
        .req_iack_i(req_iack), .req_level_i(req_level), .req_wdata_i(req_wdata),
        .rsp_valid_o(rsp_valid), .rsp_err_o(rsp_err), .rsp_rdata_o(rsp_rdata),
        .bus_addr_o(bus_addr), .bus_fc_o(bus_fc), .bus_as_n_o(as_n), .bus_rw_o(rw),
        .bus_uds_n_o(uds_n), .bus_lds_n_o(lds_n), .bus_dout_o(dout), .bus_doe_o(doe),
        .bus_din_i(bus_din), .bus_ack_n_i(ack_n), .bus_berr_n_i(berr_n)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h (txn %0d)", req, what, act, exp, n_txn);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WATCHDOG) begin
            n_fail++;
            $display("FAIL watchdog expired: actual %0d expected below %0d", cyc, WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // term: 0 acknowledge, 1 bus error, 2 both together (applied on the first bus cycle)
    task automatic run_txn(input bit wr, input bit word, input bit iack, input logic [23:0] addr,
                           input logic [2:0] lvl, input logic [2:0] fc, input logic [15:0] wd,
                           input int term, input int waits);
        logic [15:0] din0, din1, exp_rd, exp_do;
        logic [23:0] ea, seg_addr;
        logic [2:0]  efc;
        bit narrow, mis, ewr, eu, el, berr_now;
        int nseg;
        string lane_req;
        n_txn++;
        narrow = byte_bus;
        mis    = word && addr[0] && !iack;
        ewr    = wr && !iack;
        din0   = 16'h3C00 ^ {n_txn[7:0], ~n_txn[7:0]};
        din1   = din0 ^ 16'h5A5A;
        @(negedge clk);
        chk(req_ready == 1'b1, "R2", "ready while idle", {31'd0, req_ready}, 32'd1);
        req_valid = 1'b1; req_write = wr; req_word = word; req_iack = iack;
        req_addr = addr; req_level = lvl; req_fc = fc; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        if (mis) begin
            chk(rsp_valid && rsp_err, "R10", "odd word rejected", {30'd0, rsp_valid, rsp_err}, 32'd3);
            chk(as_n == 1'b1, "R10", "no strobe on odd word", {31'd0, as_n}, 32'd1);
            @(negedge clk);
            chk(!rsp_valid && as_n, "R10", "single pulse, no cycle", {30'd0, rsp_valid, as_n}, 32'd1);
            return;
        end
        nseg = (narrow && word && !iack) ? 2 : 1;
        ea   = iack ? {20'hFFFFF, lvl, 1'b1} : addr;
        efc  = iack ? 3'b111 : fc;
        lane_req = iack ? "R8" : (narrow ? (word ? "R7" : "R6") : "R4");
        if (narrow || iack) begin eu = 1'b1; el = 1'b0; end
        else if (word) begin eu = 1'b0; el = 1'b0; end
        else begin eu = addr[0]; el = !addr[0]; end
        if (iack) exp_rd = {8'h00, din0[7:0]};
        else if (narrow && word) exp_rd = {din0[7:0], din1[7:0]};
        else if (narrow) exp_rd = {8'h00, din0[7:0]};
        else if (word) exp_rd = din0;
        else exp_rd = addr[0] ? {8'h00, din0[7:0]} : {8'h00, din0[15:8]};
        berr_now = 1'b0;
        for (int seg = 0; seg < nseg; seg++) begin
            seg_addr = (seg == 1) ? (ea | 24'd1) : ea;
            if (!narrow && word) exp_do = wd;
            else if (narrow && word) exp_do = (seg == 0) ? {2{wd[15:8]}} : {2{wd[7:0]}};
            else exp_do = {2{wd[7:0]}};
            // setup clock
            chk(as_n && uds_n && lds_n, "R2", "strobes negated in setup", {29'd0, as_n, uds_n, lds_n}, 32'd7);
            chk(bus_addr == seg_addr, lane_req, "address", {8'd0, bus_addr}, {8'd0, seg_addr});
            chk(bus_fc == efc, iack ? "R8" : "R2", "space code", {29'd0, bus_fc}, {29'd0, efc});
            chk(rw == !ewr && doe == ewr, iack ? "R8" : "R5", "direction in setup", {30'd0, rw, doe}, {30'd0, !ewr, ewr});
            @(negedge clk);
            for (int w = 0; w <= waits; w++) begin
                chk(as_n == 1'b0, "R2", "address strobe active", {31'd0, as_n}, 32'd0);
                chk(uds_n == eu && lds_n == el, lane_req, "byte strobes", {30'd0, uds_n, lds_n}, {30'd0, eu, el});
                chk(bus_addr == seg_addr && bus_fc == efc, "R3", "address held", {8'd0, bus_addr}, {8'd0, seg_addr});
                if (ewr) begin
                    if (narrow) chk(dout[7:0] == exp_do[7:0], lane_req, "write byte", {24'd0, dout[7:0]}, {24'd0, exp_do[7:0]});
                    else chk(dout == exp_do, "R4", "write lanes", {16'd0, dout}, {16'd0, exp_do});
                    chk(doe && !rw, "R5", "driving write", {30'd0, doe, rw}, 32'd2);
                end
                if (w < waits) @(negedge clk);
            end
            bus_din = (seg == 0) ? din0 : din1;
            berr_now = (seg == 0) && (term != 0);
            if (berr_now) berr_n = 1'b0;
            if (!(seg == 0 && term == 1)) ack_n = 1'b0;
            @(negedge clk);
            ack_n = 1'b1; berr_n = 1'b1; bus_din = 16'hDEAD;
            chk(as_n && uds_n && lds_n, "R2", "release after termination", {29'd0, as_n, uds_n, lds_n}, 32'd7);
            chk(doe == ewr, "R5", "hold data after termination", {31'd0, doe}, {31'd0, ewr});
            @(negedge clk);
            if (berr_now) break;
        end
        chk(rsp_valid == 1'b1, berr_now ? "R9" : "R2", "response pulse", {31'd0, rsp_valid}, 32'd1);
        if (term == 2) chk(rsp_err == 1'b1, "R11", "error wins over ack", {31'd0, rsp_err}, 32'd1);
        else if (term == 1) chk(rsp_err == 1'b1, "R9", "error status", {31'd0, rsp_err}, 32'd1);
        else chk(rsp_err == 1'b0, "R12", "clean status", {31'd0, rsp_err}, 32'd0);
        if (term == 0 && !ewr)
            chk(rsp_rdata == exp_rd, lane_req, "read data", {16'd0, rsp_rdata}, {16'd0, exp_rd});
        chk(rw && !doe, "R5", "idle bus direction", {30'd0, rw, doe}, 32'd2);
        @(negedge clk);
        chk(!rsp_valid && as_n, "R2", "pulse one clock", {30'd0, rsp_valid, as_n}, 32'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(as_n && uds_n && lds_n, "R1", "strobes in reset", {29'd0, as_n, uds_n, lds_n}, 32'd7);
        rst_n = 1'b1;
        @(negedge clk);
        chk(as_n && uds_n && lds_n && rw, "R1", "bus idle after reset", {28'd0, as_n, uds_n, lds_n, rw}, 32'hF);
        chk(!doe && req_ready && !rsp_valid, "R1", "port state after reset", {29'd0, doe, req_ready, rsp_valid}, 32'd2);
        for (int m = 0; m < 2; m++) begin
            byte_bus = m[0];
            for (int wr = 0; wr < 2; wr++)
                for (int wd = 0; wd < 2; wd++)
                    for (int a = 0; a < 4; a++)
                        for (int t = 0; t < 3; t++)
                            for (int ws = 0; ws < 3; ws++)
                                run_txn(wr[0], wd[0], 1'b0, {20'h4B2C1 + 20'(a * 7), a[1:0], 2'b00} | 24'(a),
                                        3'd0, 3'(a + t + 1), 16'hA5C3 ^ 16'(a * 16'h1111 + t),
                                        t, ws);
            for (int l = 0; l < 8; l++) begin
                run_txn(l[0], 1'b1, 1'b1, 24'h000123, l[2:0], 3'd2, 16'h0F0F, 0, l % 3);
            end
            run_txn(1'b0, 1'b0, 1'b1, 24'h0, 3'd5, 3'd1, 16'h0, 1, 0);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule